// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects interrupt requests for a small group of processors and tells each processor which request it should serve next. Fifteen regular sources, numbered 1 to 15, are prioritised by number, so a larger number wins. When the extended range is built in, sources 16 to 31 also exist. Those sources do not reach a processor directly. Instead they raise one chosen regular line, the proxy line, and the controller records which extended source won in an identification register kept for each processor.

Software works the controller through a simple word-addressed register bus. It can read the shared pending word and clear it with write-one bits. It can raise software requests through a force word. A broadcast word sends forced requests to every processor at once. Each processor has its own enable mask, its own force word and its own identification register. Each processor sees a 4-bit level output and returns an acknowledge that carries the level it took.

Top module: `irq_mp_ctrl`

## Requirements
- R1: After reset every level output is 0, and the pending word, every mask and every force word read 0.
- R2: A one-cycle high on irqIn bit n sets pending bit n at the next clock edge, for n from 1 to 15, and also for n from 16 to 31 when the extended range is built in. Bit 0 has no effect, so pending bit 0 always reads 0. The pending word is read at word address 0.
- R3: A bus write to word address 2 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 stay as they were.
- R4: Processor c has a mask at word address 8+c. A 1 bit enables that source for that processor, and a 0 bit hides it.
- R5: The level of processor c (cpuLvl bits 4c+3..4c) is the highest source number in 1..15 that is pending or forced for c and enabled in c's mask. The proxy line also counts when it has an enabled extended request. The level is 0 when no such source exists.
- R6: A write to word address 1 sets force bits for each data bit that is 1. A bit whose broadcast bit (word address 4) is 1 is forced on every processor. A bit whose broadcast bit is 0 is forced on processor 0 only. The force word of processor c reads at word address 12+c.
- R7: An acknowledge from processor c carrying level L clears c's force bit L if that bit is set. Otherwise it clears pending bit L.
- R8: Word address 3 reads the CPU count minus one in bits 31:28 and a 1 in bit 27 to show broadcast support. All other bits read 0.
- R9: When processor c acknowledges the proxy line (default 12) while any enabled extended source is pending, the highest such source number is stored in c's ID register (word address 16+c, low 5 bits, bit 4 set) and that extended pending bit is cleared.
- R10: An extended source that is masked for a processor does not raise that processor's proxy line. An acknowledge of the proxy line with no enabled extended source pending loads 0 into the ID register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqIn | input | 32 | Source request pulses, bit n is source n |
| cpuAck | input | NCPU | Acknowledge, one bit per processor |
| cpuAckLvl | input | 4*NCPU | Level acknowledged, 4 bits per processor |
| cpuLvl | output | 4*NCPU | Requested level, 4 bits per processor |

## Verification
The assertions assume that a processor acknowledges only a non-zero level that it was just shown, and that software never writes the clear and force words in the same cycle that irqIn sets the same source. The bench follows both rules. It changes bus, irqIn and acknowledge inputs only on the falling edge. Each acknowledge copies the level the bench expects, and the bench checks that level first. Request pulses are kept apart from the clear writes that touch the same bits.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SrcW = 32;
  localparam int LvlW = 4;
  localparam int IdW  = 5;

  localparam logic [4:0] AddrPend   = 5'd0;
  localparam logic [4:0] AddrForce  = 5'd1;
  localparam logic [4:0] AddrClear  = 5'd2;
  localparam logic [4:0] AddrStatus = 5'd3;
  localparam logic [4:0] AddrBcast  = 5'd4;
  localparam logic [4:0] AddrMask0  = 5'd8;
  localparam logic [4:0] AddrFrc0   = 5'd12;
  localparam logic [4:0] AddrId0    = 5'd16;

  typedef struct packed {
    logic [SrcW-1:0] pendClr;
    logic [SrcW-1:0] forceClr;
    logic            idLoad;
    logic [IdW-1:0]  idVal;
  } ackStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int EXT_EN   = 1,
  parameter int EXT_LINE = 12
) (
  input  logic [SrcW-1:0]            pending,
  input  logic [NCPU-1:0][SrcW-1:0]  forceQ,
  input  logic [NCPU-1:0][SrcW-1:0]  maskQ,
  input  logic [NCPU-1:0]            cpuAck,
  input  logic [NCPU*LvlW-1:0]       cpuAckLvl,
  output logic [NCPU*LvlW-1:0]       cpuLvl,
  output ackStrobe_t [NCPU-1:0]      strobes
);
  localparam logic [LvlW-1:0] ProxyLvl = LvlW'(EXT_LINE);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [15:0]     effReq;
    logic [15:0]     extReq;
    logic            extAny;
    logic [IdW-1:0]  extIdx;
    logic [LvlW-1:0] lvl;
    logic [LvlW-1:0] ackL;

    always_comb begin
      effReq = (pending[15:0] | forceQ[c][15:0]) & maskQ[c][15:0];
      extReq = (EXT_EN != 0) ? (pending[31:16] & maskQ[c][31:16]) : 16'h0;
      extAny = |extReq;
      effReq[EXT_LINE] = effReq[EXT_LINE] | (extAny & maskQ[c][EXT_LINE]);
      effReq[0] = 1'b0;
      lvl = '0;
      for (int i = 1; i < 16; i++) if (effReq[i]) lvl = LvlW'(i);
      extIdx = '0;
      for (int i = 0; i < 16; i++) if (extReq[i]) extIdx = IdW'(16 + i);
    end

    assign cpuLvl[c*LvlW +: LvlW] = lvl;
    assign ackL = cpuAckLvl[c*LvlW +: LvlW];

    always_comb begin
      strobes[c] = '0;
      if (cpuAck[c] && ackL != '0) begin
        if (forceQ[c][ackL]) strobes[c].forceClr[ackL] = 1'b1;
        else                 strobes[c].pendClr[ackL] = 1'b1;
        if (EXT_EN != 0 && ackL == ProxyLvl) begin
          strobes[c].idLoad = 1'b1;
          if (extAny && !forceQ[c][ackL]) begin
            strobes[c].idVal = extIdx;
            strobes[c].pendClr[extIdx] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NCPU   = 2,
  parameter int EXT_EN = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [4:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic [SrcW-1:0]            irqIn,
  input  ackStrobe_t [NCPU-1:0]      strobes,
  output logic [SrcW-1:0]            pending,
  output logic [NCPU-1:0][SrcW-1:0]  forceQ,
  output logic [NCPU-1:0][SrcW-1:0]  maskQ,
  output logic [NCPU-1:0][IdW-1:0]   idQ
);
  localparam logic [SrcW-1:0] Valid = (EXT_EN != 0) ? 32'hFFFF_FFFE : 32'h0000_FFFE;
  localparam logic [3:0] CpuM1 = 4'(NCPU - 1);

  logic [SrcW-1:0] bcastQ;
  logic [SrcW-1:0] pendClrAll;
  logic            wrClr, wrForce;

  always_comb begin
    pendClrAll = '0;
    for (int c = 0; c < NCPU; c++) pendClrAll = pendClrAll | strobes[c].pendClr;
  end

  assign wrClr   = busWe && busAddr == AddrClear;
  assign wrForce = busWe && busAddr == AddrForce;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      bcastQ  <= '0;
    end else begin
      pending <= (pending & ~pendClrAll & ~(wrClr ? busWdata : 32'h0)) | (irqIn & Valid);
      if (busWe && busAddr == AddrBcast) bcastQ <= busWdata & Valid;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [SrcW-1:0] setBits;
    assign setBits = wrForce ? (busWdata & Valid & (bcastQ | ((c == 0) ? ~bcastQ : 32'h0)))
                             : 32'h0;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        forceQ[c] <= '0;
        maskQ[c]  <= '0;
        idQ[c]    <= '0;
      end else begin
        forceQ[c] <= (forceQ[c] & ~strobes[c].forceClr) | setBits;
        if (busWe && busAddr == AddrMask0 + 5'(c)) maskQ[c] <= busWdata & Valid;
        if (strobes[c].idLoad) idQ[c] <= strobes[c].idVal;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      AddrPend:   busRdata = pending;
      AddrForce:  busRdata = forceQ[0];
      AddrStatus: busRdata = {CpuM1, 1'b1, 27'h0};
      AddrBcast:  busRdata = bcastQ;
      default: begin
        for (int c = 0; c < NCPU; c++) begin
          if (busAddr == AddrMask0 + 5'(c)) busRdata = maskQ[c];
          if (busAddr == AddrFrc0 + 5'(c))  busRdata = forceQ[c];
          if (busAddr == AddrId0 + 5'(c))   busRdata = {27'h0, idQ[c]};
        end
      end
    endcase
  end
endmodule

// File: rtl/irq_mp_ctrl.sv
module irq_mp_ctrl
  import irqc_pkg::*;
#(
  parameter int NCPU     = 2,
  parameter int EXT_EN   = 1,
  parameter int EXT_LINE = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [4:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [31:0]          irqIn,
  input  logic [NCPU-1:0]      cpuAck,
  input  logic [NCPU*4-1:0]    cpuAckLvl,
  output logic [NCPU*4-1:0]    cpuLvl
);
  logic [SrcW-1:0]           pending;
  logic [NCPU-1:0][SrcW-1:0] forceQ;
  logic [NCPU-1:0][SrcW-1:0] maskQ;
  logic [NCPU-1:0][IdW-1:0]  idQ;
  ackStrobe_t [NCPU-1:0]     strobes;

  irqc_datapath #(.NCPU(NCPU), .EXT_EN(EXT_EN)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .strobes(strobes), .pending(pending), .forceQ(forceQ),
    .maskQ(maskQ), .idQ(idQ)
  );

  irqc_ctrl #(.NCPU(NCPU), .EXT_EN(EXT_EN), .EXT_LINE(EXT_LINE)) u_ctrl (
    .pending(pending), .forceQ(forceQ), .maskQ(maskQ), .cpuAck(cpuAck),
    .cpuAckLvl(cpuAckLvl), .cpuLvl(cpuLvl), .strobes(strobes)
  );
endmodule

// File: rtl/irq_mp_ctrl_checker.sv
module irq_mp_ctrl_checker #(
  parameter int NCPU   = 2,
  parameter int EXT_EN = 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busWe,
  input logic [4:0]                busAddr,
  input logic [31:0]               busWdata,
  input logic [31:0]               irqIn,
  input logic [NCPU-1:0]           cpuAck,
  input logic [NCPU*4-1:0]         cpuAckLvl,
  input logic [NCPU*4-1:0]         cpuLvl,
  input logic [31:0]               pending,
  input logic [NCPU-1:0][31:0]     forceQ,
  input logic [NCPU-1:0][31:0]     maskQ,
  input logic [NCPU-1:0][4:0]      idQ
);
  localparam logic [31:0] Valid = (EXT_EN != 0) ? 32'hFFFF_FFFE : 32'h0000_FFFE;

  // R2: a request pulse is pending one edge later
  p_input_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    |(irqIn & Valid) |=> (($past(irqIn) & Valid & ~pending) == 32'h0));

  // R3: write-one clear leaves no addressed bit set unless re-requested
  p_clear_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 5'd2) |=> ((pending & $past(busWdata) & ~$past(irqIn)) == 32'h0));

  // R6: a force write sets at least processor 0's bit or every bit
  p_force_cpu0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 5'd1) |=> ((forceQ[0] & $past(busWdata) & Valid)
                                    == ($past(busWdata) & Valid)));

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    // R4: a presented level is always enabled in that processor's mask
    p_level_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
      (cpuLvl[c*4 +: 4] != 4'd0) |-> maskQ[c][cpuLvl[c*4 +: 4]]);

    // R7: acknowledge of an unforced non-proxy level clears its pending bit
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cpuAck[c] && cpuAckLvl[c*4 +: 4] != 4'd0 && cpuAckLvl[c*4 +: 4] != 4'd12
       && !forceQ[c][cpuAckLvl[c*4 +: 4]] && !irqIn[cpuAckLvl[c*4 +: 4]])
      |=> !pending[$past(cpuAckLvl[c*4 +: 4])]);

    // R9: a non-zero ID always carries the extended marker bit
    p_id_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
      (idQ[c] != 5'd0) |-> idQ[c][4]);
  end
endmodule

bind irq_mp_ctrl irq_mp_ctrl_checker #(.NCPU(NCPU), .EXT_EN(EXT_EN)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .irqIn(irqIn), .cpuAck(cpuAck), .cpuAckLvl(cpuAckLvl), .cpuLvl(cpuLvl),
  .pending(pending), .forceQ(forceQ), .maskQ(maskQ), .idQ(idQ)
);

// File: tb/irq_mp_ctrl_tb.sv
module irq_mp_ctrl_tb;
  localparam int NCPU = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWe = 1'b0;
  logic [4:0]        busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [31:0]       irqIn = '0;
  logic [NCPU-1:0]   cpuAck = '0;
  logic [NCPU*4-1:0] cpuAckLvl = '0;
  logic [NCPU*4-1:0] cpuLvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_mp_ctrl #(.NCPU(NCPU), .EXT_EN(1), .EXT_LINE(12)) u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqIn(irqIn), .cpuAck(cpuAck), .cpuAckLvl(cpuAckLvl),
    .cpuLvl(cpuLvl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk); irqIn = bits;
    @(negedge clk); irqIn = '0;
  endtask

  task automatic ack(input int c, input logic [3:0] l);
    @(negedge clk); cpuAck[c] = 1'b1; cpuAckLvl[c*4 +: 4] = l;
    @(negedge clk); cpuAck = '0; cpuAckLvl = '0;
  endtask

  function automatic logic [31:0] lv(input int c);
    return {28'h0, cpuLvl[c*4 +: 4]};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 lvl0", lv(0), 0);
    chk("R1 lvl1", lv(1), 0);
    rd(5'd0, d);  chk("R1 pending", d, 0);
    rd(5'd8, d);  chk("R1 mask0", d, 0);
    rd(5'd13, d); chk("R1 force1", d, 0);
    rd(5'd3, d);  chk("R8 status", d, 32'h1800_0000);
  endtask

  task automatic t_pending;
    logic [31:0] d;
    pulse(32'h0000_0029);
    rd(5'd0, d); chk("R2 pending bits 3,5, bit0 ignored", d, 32'h28);
    chk("R4 masked gives level 0", lv(0), 0);
  endtask

  task automatic t_mask_prio;
    wr(5'd8, 32'h28);
    wr(5'd9, 32'h08);
    chk("R5 cpu0 highest", lv(0), 5);
    chk("R4 cpu1 own mask", lv(1), 3);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(5'd2, 32'h20);
    rd(5'd0, d); chk("R3 clear one bit", d, 32'h08);
    chk("R3 level drops", lv(0), 3);
  endtask

  task automatic t_ack_pend;
    logic [31:0] d;
    ack(0, 4'd3);
    rd(5'd0, d); chk("R7 ack clears pending", d, 0);
    chk("R7 cpu1 level gone", lv(1), 0);
  endtask

  task automatic t_force_single;
    logic [31:0] d;
    wr(5'd8, 32'h68);
    wr(5'd9, 32'h48);
    wr(5'd1, 32'h40);
    rd(5'd12, d); chk("R6 force cpu0", d, 32'h40);
    rd(5'd13, d); chk("R6 force cpu1 untouched", d, 0);
    rd(5'd0, d);  chk("R6 pending untouched", d, 0);
    chk("R5 forced level", lv(0), 6);
    chk("R6 cpu1 no level", lv(1), 0);
    ack(0, 4'd6);
    rd(5'd12, d); chk("R7 ack clears force", d, 0);
  endtask

  task automatic t_broadcast;
    logic [31:0] d;
    wr(5'd4, 32'h80);
    wr(5'd8, 32'hE8);
    wr(5'd9, 32'hC8);
    wr(5'd1, 32'h80);
    chk("R6 bcast lvl0", lv(0), 7);
    chk("R6 bcast lvl1", lv(1), 7);
    ack(1, 4'd7);
    rd(5'd13, d); chk("R7 cpu1 force cleared", d, 0);
    rd(5'd12, d); chk("R7 cpu0 force kept", d, 32'h80);
    ack(0, 4'd7);
    chk("R7 cpu0 done", lv(0), 0);
  endtask

  task automatic t_extended;
    logic [31:0] d;
    wr(5'd8, 32'h0005_1000);
    pulse(32'h0005_0000);
    chk("R9 proxy level", lv(0), 12);
    chk("R10 cpu1 masked ext", lv(1), 0);
    ack(0, 4'd12);
    rd(5'd16, d); chk("R9 id highest", d, 32'h12);
    rd(5'd0, d);  chk("R9 ext pending cleared", d, 32'h0001_0000);
    chk("R9 proxy still", lv(0), 12);
    ack(0, 4'd12);
    rd(5'd16, d); chk("R9 id next", d, 32'h10);
    chk("R9 proxy idle", lv(0), 0);
  endtask

  task automatic t_ext_none;
    logic [31:0] d;
    pulse(32'h0000_1000);
    chk("R5 regular proxy line", lv(0), 12);
    ack(0, 4'd12);
    rd(5'd16, d); chk("R10 id zero", d, 0);
    rd(5'd0, d);  chk("R10 pending clear", d, 0);
    wr(5'd8, 32'h1000);
    pulse(32'h0010_0000);
    chk("R10 masked ext no proxy", lv(0), 0);
    rd(5'd0, d);  chk("R2 ext pending", d, 32'h0010_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_mask_prio();
    t_clear();
    t_ack_pend();
    t_force_single();
    t_broadcast();
    t_extended();
    t_ext_none();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule